// File: doc/BRIEF.md
# Multi-mode timer and event counter

A 16-bit up-counter with a reload value, driven in one of three ways chosen by a control register: counting qualifying edges of an asynchronous external pin, counting single-cycle tick pulses from an outside prescaler, or timing a single pulse on the external pin in prescaler ticks. When the count passes its all-ones value, it reloads from the reload register and raises a sticky interrupt flag that software clears with a one-cycle strobe.

Software reaches the counter over a plain 8-bit register bus with three addresses. The low half of any 16-bit transfer passes through a byte buffer. A write places the low byte in the buffer first, then the high-byte write commits both bytes at once. A read of the high byte freezes the matching low byte into the buffer. A torn value therefore never appears while the counter runs. The pulse-width mode is one-shot. It arms on an edge, stops on the return edge, and then drops its own enable bit, so the result stays put until software arms it again.

There is no streaming data path. Every pin is a plain control or register-bus signal, with no valid/ready handshake and no back-pressure. A bus access completes in the cycle in which it is presented.

Top module: `multimode_counter`

## Requirements
- R1: After reset the count, the reload value, the byte buffer and the control register read as zero, and `irq` is low.
- R2: A bus write to address 0 loads only the byte buffer. The count and the reload value keep their contents.
- R3: A bus write to address 1 loads the count and the reload value, both with {written byte, byte buffer}, on the same clock edge.
- R4: A bus read of address 1 returns the count's high byte combinationally and, on that clock edge, copies the count's low byte into the buffer. A read of address 0 returns the buffer.
- R5: Control register at address 2: bits [1:0] mode (00 off, 01 event, 10 timer, 11 pulse width), bit 2 edge select, bit 3 enable. It reads back as written. With mode 00 or enable 0, the count holds.
- R6: In event mode the count rises by one per edge on `ext_in` (rising when edge select is 1, falling when it is 0), and `tick_in` has no effect.
- R7: In timer mode the count rises by one per cycle with `tick_in` high, and `ext_in` has no effect.
- R8: An increment from FFFFh loads the reload value instead and sets `irq`.
- R9: `irq` stays set until a cycle with `irq_clr` high and no new wrap. A wrap wins over a clear in the same cycle.
- R10: In pulse-width mode, a start edge on `ext_in` (rising for edge select 1, falling for 0) begins counting `tick_in` pulses, and the opposite edge ends it. With `tick_in` held high, a level held for N clock cycles yields a count of N.
- R11: The end of a pulse-width measurement clears the enable bit. Further edges then leave the count unchanged until software sets enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 low/buffer, 1 high, 2 control |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; needed for the side effect of a high-byte read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_in | input | 1 | Asynchronous external event / pulse input |
| tick_in | input | 1 | One-cycle enable pulses from an outside prescaler |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| irq | output | 1 | Sticky overflow interrupt flag |

## Verification
The assertions watch every cycle for the register-bus rules: the buffer-only low write, the joint commit of both halves, and the freeze of the low byte on a high read. They also check the reload on wrap, the holding of the count while stopped, the stickiness of the flag, and that the enable bit falls without a bus write only in pulse-width mode. The exact counts can only be shown by the bench's sweeps. These are the number of edges seen per polarity, the number of ticks counted, and the measured pulse lengths through the synchronizer latency. The same holds for the one-shot hold of a result against later pulses and for a consistent 16-bit read taken while the count crosses a byte boundary.

// File: rtl/mmtc_pkg.sv
package mmtc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } mode_e;

  localparam logic [1:0] ADR_LO  = 2'd0;
  localparam logic [1:0] ADR_HI  = 2'd1;
  localparam logic [1:0] ADR_CTL = 2'd2;

  localparam int CTL_EDGE_BIT = 2;
  localparam int CTL_EN_BIT   = 3;
endpackage

// File: rtl/mmtc_sync_edge.sv
module mmtc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      prev  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], din};
      prev  <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/mmtc_pulse_meas.sv
module mmtc_pulse_meas (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pol,
  input  logic rise,
  input  logic fall,
  output logic measuring,
  output logic done
);
  logic start_ev, stop_ev;

  assign start_ev = pol ? rise : fall;
  assign stop_ev  = pol ? fall : rise;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm)
      measuring <= 1'b0;
    else if (!measuring && start_ev)
      measuring <= 1'b1;
    else if (measuring && stop_ev)
      measuring <= 1'b0;
  end

  assign done = arm & measuring & stop_ev;
endmodule

// File: rtl/mmtc_count_core.sv
module mmtc_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] preload,
  output logic         wrap
);
  logic at_top;

  assign at_top = &cnt;
  assign wrap   = inc & at_top & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      preload <= '0;
    end else if (load) begin
      cnt     <= load_val;
      preload <= load_val;
    end else if (inc) begin
      cnt <= at_top ? preload : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/multimode_counter.sv
module multimode_counter
  import mmtc_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ext_in,
  input  logic             tick_in,
  input  logic             irq_clr,
  output logic             irq
);
  localparam int CNT_W = 2 * BUS_W;

  mode_e            mode_q;
  logic             edge_q, en_q;
  logic [BUS_W-1:0] lo_buf;
  logic [CNT_W-1:0] cnt, preload;
  logic             cnt_inc, wrap;
  logic             lo_wr, hi_wr, ctl_wr, hi_rd;
  logic             ext_lvl, ext_rise, ext_fall;
  logic             measuring, meas_done, pulse_arm;
  logic [BUS_W-1:0] ctl_view;

  assign lo_wr  = bus_wr && bus_addr == ADR_LO;
  assign hi_wr  = bus_wr && bus_addr == ADR_HI;
  assign ctl_wr = bus_wr && bus_addr == ADR_CTL;
  assign hi_rd  = bus_rd && bus_addr == ADR_HI;

  mmtc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in),
    .level(ext_lvl), .rise(ext_rise), .fall(ext_fall)
  );

  assign pulse_arm = en_q && mode_q == MODE_PULSE;

  mmtc_pulse_meas u_meas (
    .clk(clk), .rst_n(rst_n), .arm(pulse_arm), .pol(edge_q),
    .rise(ext_rise), .fall(ext_fall),
    .measuring(measuring), .done(meas_done)
  );

  always_comb begin
    cnt_inc = 1'b0;
    if (en_q) begin
      unique case (mode_q)
        MODE_EVENT: cnt_inc = edge_q ? ext_rise : ext_fall;
        MODE_TIMER: cnt_inc = tick_in;
        MODE_PULSE: cnt_inc = measuring & tick_in;
        default:    cnt_inc = 1'b0;
      endcase
    end
  end

  mmtc_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .load(hi_wr), .load_val({bus_wdata, lo_buf}),
    .inc(cnt_inc), .cnt(cnt), .preload(preload), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      edge_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (ctl_wr) begin
      mode_q <= mode_e'(bus_wdata[1:0]);
      edge_q <= bus_wdata[CTL_EDGE_BIT];
      en_q   <= bus_wdata[CTL_EN_BIT];
    end else if (meas_done) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      lo_buf <= '0;
    else if (lo_wr)
      lo_buf <= bus_wdata;
    else if (hi_rd)
      lo_buf <= cnt[BUS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq <= 1'b0;
    else if (wrap)
      irq <= 1'b1;
    else if (irq_clr)
      irq <= 1'b0;
  end

  always_comb begin
    ctl_view               = '0;
    ctl_view[1:0]          = mode_q;
    ctl_view[CTL_EDGE_BIT] = edge_q;
    ctl_view[CTL_EN_BIT]   = en_q;
  end

  always_comb begin
    unique case (bus_addr)
      ADR_LO:  bus_rdata = lo_buf;
      ADR_HI:  bus_rdata = cnt[CNT_W-1:BUS_W];
      ADR_CTL: bus_rdata = ctl_view;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/multimode_counter_chk.sv
module multimode_counter_chk #(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lo_wr,
  input logic             hi_wr,
  input logic             hi_rd,
  input logic             ctl_wr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] lo_buf,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preload,
  input logic             cnt_inc,
  input logic             en,
  input logic [1:0]       mode,
  input logic             irq,
  input logic             irq_clr
);
  logic [BUS_W-1:0] cnt_lo;
  assign cnt_lo = cnt[BUS_W-1:0];

  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && (&cnt) && !hi_wr) |=> (cnt == $past(preload)) && irq); // R8

  AST_LO_WRITE_BUFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (lo_buf == $past(bus_wdata)) && (preload == $past(preload))); // R2

  AST_HI_WRITE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (cnt == {$past(bus_wdata), $past(lo_buf)}) && (preload == cnt)); // R3

  AST_HI_READ_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> lo_buf == $past(cnt_lo)); // R4

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en || mode == 2'b00) && !hi_wr) |=> $stable(cnt)); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R9

  AST_EN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ctl_wr && mode != 2'b11) |=> en); // R11
endmodule

bind multimode_counter multimode_counter_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr), .hi_rd(hi_rd),
  .ctl_wr(ctl_wr), .bus_wdata(bus_wdata), .lo_buf(lo_buf), .cnt(cnt),
  .preload(preload), .cnt_inc(cnt_inc), .en(en_q), .mode(mode_q),
  .irq(irq), .irq_clr(irq_clr)
);

// File: tb/multimode_counter_test.sv
module multimode_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0;
  logic       tick_in = 1'b0;
  logic       irq_clr = 1'b0;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  multimode_counter uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .tick_in(tick_in), .irq_clr(irq_clr), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic write_cnt(input logic [15:0] v);
    bus_write(2'd0, v[7:0]);
    bus_write(2'd1, v[15:8]);
  endtask

  task automatic read_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    bus_read(2'd1, h);
    bus_read(2'd0, l);
    v = {h, l};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    read_cnt(v);          check("R1 count", v, 16'h0000);
    bus_read(2'd2, b);    check("R1 control", {8'h0, b}, 16'h0000);
    check("R1 irq", {15'h0, irq}, 16'h0000);

    // R3 joint load, R2 low write touches only the buffer
    write_cnt(16'h1234);
    read_cnt(v);          check("R3 load", v, 16'h1234);
    bus_write(2'd0, 8'hAB);
    bus_read(2'd0, b);    check("R2 buffer", {8'h0, b}, 16'h00AB);
    read_cnt(v);          check("R2 count kept", v, 16'h1234);

    // R5 control readback and holding while stopped
    bus_write(2'd2, 8'h08);
    bus_read(2'd2, b);    check("R5 readback", {8'h0, b}, 16'h0008);
    tick_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) ext_in = 1'b1; idle(3);
      ext_in = 1'b0; idle(3);
    end
    bus_write(2'd2, 8'h02);
    bus_read(2'd2, b);    check("R5 readback", {8'h0, b}, 16'h0002);
    idle(5);
    tick_in = 1'b0;
    bus_write(2'd2, 8'h00);
    read_cnt(v);          check("R5 held", v, 16'h1234);

    // R6 event counting, both polarities, ticks running
    for (int e = 0; e < 2; e++) begin
      for (int k = 1; k <= 6; k++) begin
        write_cnt(16'h0000);
        tick_in = 1'b1;
        bus_write(2'd2, 8'h09 | 8'(e << 2));
        for (int p = 0; p < k; p++) begin
          @(negedge clk) ext_in = 1'b1; idle(3);
          ext_in = 1'b0; idle(3);
        end
        ext_in = 1'b1; idle(6);
        bus_write(2'd2, 8'h00);
        tick_in = 1'b0;
        ext_in = 1'b0; idle(5);
        read_cnt(v);
        check(e ? "R6 rising edges" : "R6 falling edges", v, 16'(e ? k + 1 : k));
      end
    end

    // R7 timer counting, ext toggling ignored
    for (int m = 1; m <= 25; m += 6) begin
      write_cnt(16'h0100);
      bus_write(2'd2, 8'h0A);
      for (int t = 0; t < m; t++) begin
        @(negedge clk) tick_in = 1'b1; ext_in = ~ext_in;
        @(negedge clk) tick_in = 1'b0;
      end
      bus_write(2'd2, 8'h00);
      ext_in = 1'b0; idle(5);
      read_cnt(v);          check("R7 ticks", v, 16'(16'h0100 + m));
    end

    // R4 consistent read across a byte boundary while running
    write_cnt(16'h00FF);
    tick_in = 1'b1;
    bus_write(2'd2, 8'h0A);
    bus_read(2'd1, b);    check("R4 high byte", {8'h0, b}, 16'h0001);
    idle(3);
    bus_read(2'd0, b);    check("R4 frozen low", {8'h0, b}, 16'h0000);
    bus_read(2'd0, b);    check("R4 still frozen", {8'h0, b}, 16'h0000);
    bus_write(2'd2, 8'h00);
    tick_in = 1'b0;

    // R8 reload on wrap, R9 sticky flag and clear
    write_cnt(16'hFFFD);
    bus_write(2'd2, 8'h0A);
    for (int t = 0; t < 5; t++) begin
      @(negedge clk) tick_in = 1'b1;
      @(negedge clk) tick_in = 1'b0;
    end
    bus_write(2'd2, 8'h00);
    read_cnt(v);          check("R8 reload", v, 16'hFFFF);
    check("R8 irq set", {15'h0, irq}, 16'h0001);
    idle(4);
    check("R9 irq held", {15'h0, irq}, 16'h0001);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    check("R9 irq cleared", {15'h0, irq}, 16'h0000);

    // R10/R11 pulse width, both polarities
    for (int pol = 1; pol >= 0; pol--) begin
      for (int n = 1; n <= 9; n += 2) begin
        tick_in = 1'b1;
        ext_in = (pol == 0);
        idle(5);
        write_cnt(16'h0000);
        bus_write(2'd2, 8'h0B | 8'(pol << 2));
        idle(4);
        @(negedge clk) ext_in = ~ext_in;
        idle(n);
        ext_in = ~ext_in;
        idle(6);
        bus_read(2'd2, b);
        check("R11 enable cleared", {8'h0, b}, 16'(8'h03 | 8'(pol << 2)));
        read_cnt(v);      check("R10 width", v, 16'(n));
        ext_in = ~ext_in; idle(4);
        ext_in = ~ext_in; idle(6);
        read_cnt(v);      check("R11 result held", v, 16'(n));
        bus_write(2'd2, 8'h00);
        tick_in = 1'b0;
        ext_in = 1'b0;
      end
    end

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule